// File: doc/BRIEF.md
# Dual-Channel Nibble-Loaded Double-Buffered Code Register

This block is the digital front end of a two-channel 12-bit converter. A processor drives a 4-bit data bus, a 3-bit address, active-low chip select and write strobes, an active-low update strobe and an active-high clear. Each channel builds its 12-bit word in a first-rank input register, written one nibble at a time. The word reaches the channel's output code only when a separate transfer is requested. A transfer can target one channel through an address code, or both channels at once through the update strobe.

All bus pins are brought into the system clock domain through a synchroniser chain. A bus cycle acts once, when the synchronised write strobe returns high. The address, data, chip select, update and clear values seen at that moment decide the action. The two 12-bit outputs drive the analog converters, which lie outside this block.

Top module: `dual_nibble_dac_regs`

## Requirements
- R1: Address codes with write pick one nibble register: 0, 1 and 2 load bits [3:0], [7:4] and [11:8] of channel A; 4, 5 and 6 load the same nibbles of channel B. A word written in any nibble order shows up at the output after a transfer.
- R2: With upd_n high, address 3 copies channel A's input word to code_a and leaves code_b as it was. Address 7 does the same for channel B.
- R3: A write with cs_n high changes no register.
- R4: A nibble write never changes an output code directly. Outputs change only on a transfer or a clear.
- R5: clr high clears all six nibble registers and both output codes to zero. It wins over a write or transfer acting in the same cycle.
- R6: A write with upd_n low copies both input words to both output codes on the same clock edge. Combining it with address 3 or 7 gives the same result. When it is combined with a nibble address, the outputs take the input words from before that nibble write.
- R7: A write acts exactly once, on the return of wr_n to high. It takes effect at the third clock edge after the first edge that samples wr_n high, using the bus values sampled at that first edge. Holding wr_n low has no effect.
- R8: After rst_n all registers hold zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low system reset |
| bus_data | input | 4 | Nibble data bus |
| bus_addr | input | 3 | Register / transfer select |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low, acts on rising edge |
| upd_n | input | 1 | Simultaneous transfer strobe, active low |
| clr | input | 1 | Clear of all registers, active high |
| code_a | output | 12 | Output code of channel A |
| code_b | output | 12 | Output code of channel B |

## Verification
A corrupted input nibble cannot be seen until the next transfer. It then appears as a wrong field in code_a or code_b on the third edge after the transfer strobe returns high. A misrouted transfer or update shows up one edge earlier than the model predicts, or in the wrong channel, at the moment the model expects the output to hold. A clear that fails to reach the first rank appears only at a later transfer, so a transfer after the clear is part of the check.

// File: rtl/dnr_pkg.sv
package dnr_pkg;
  parameter int NIB_W   = 4;
  parameter int NIB_CNT = 3;
  parameter int ADDR_W  = 3;
  parameter int CODE_W  = NIB_W * NIB_CNT;
  parameter int SYNC_STAGES = 2;

  // Raw bus bundle carried through the synchroniser
  typedef struct packed {
    logic              clr;
    logic              wr_n;
    logic              cs_n;
    logic              upd_n;
    logic [ADDR_W-1:0] addr;
    logic [NIB_W-1:0]  data;
  } bus_t;

  localparam int BUS_W = $bits(bus_t);

  // Address bits [1:0] == 3 request a transfer, bit 2 picks the channel
  function automatic logic addr_is_xfer(input logic [ADDR_W-1:0] a);
    return a[1:0] == 2'b11;
  endfunction

  function automatic logic addr_chan(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1];
  endfunction

  function automatic logic [1:0] addr_nib(input logic [ADDR_W-1:0] a);
    return a[1:0];
  endfunction
endpackage

// File: rtl/dnr_sync.sv
module dnr_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= RST_VAL;
          else        chain[0] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[s] <= RST_VAL;
          else        chain[s] <= chain[s-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/dnr_cmd_capture.sv
module dnr_cmd_capture
  import dnr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  bus_t              bus_s,
  output logic              wr_edge,
  output logic              cmd_fire,
  output logic              cmd_upd,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [NIB_W-1:0]  cmd_data,
  output logic              clr_apply
);
  logic wr_last;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) wr_last <= 1'b1;
    else        wr_last <= bus_s.wr_n;

  // trailing edge of the active-low strobe
  assign wr_edge = bus_s.wr_n & ~wr_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_fire  <= 1'b0;
      cmd_upd   <= 1'b0;
      cmd_addr  <= '0;
      cmd_data  <= '0;
      clr_apply <= 1'b0;
    end else begin
      cmd_fire  <= wr_edge & ~bus_s.cs_n;
      clr_apply <= bus_s.clr;
      if (wr_edge) begin
        cmd_upd  <= ~bus_s.upd_n;
        cmd_addr <= bus_s.addr;
        cmd_data <= bus_s.data;
      end
    end
  end
endmodule

// File: rtl/dnr_channel.sv
module dnr_channel
  import dnr_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic [NIB_CNT-1:0] nib_we,
  input  logic [NIB_W-1:0]   nib_data,
  input  logic               xfer,
  output logic [CODE_W-1:0]  in_word,
  output logic [CODE_W-1:0]  out_code
);
  genvar k;
  generate
    for (k = 0; k < NIB_CNT; k++) begin : g_nib
      logic [NIB_W-1:0] nib_q;
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)         nib_q <= '0;
        else if (clr)       nib_q <= '0;
        else if (nib_we[k]) nib_q <= nib_data;
      assign in_word[k*NIB_W +: NIB_W] = nib_q;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    out_code <= '0;
    else if (clr)  out_code <= '0;
    else if (xfer) out_code <= in_word;
endmodule

// File: rtl/dual_nibble_dac_regs.sv
module dual_nibble_dac_regs
  import dnr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NIB_W-1:0]  bus_data,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              cs_n,
  input  logic              wr_n,
  input  logic              upd_n,
  input  logic              clr,
  output logic [CODE_W-1:0] code_a,
  output logic [CODE_W-1:0] code_b
);
  localparam int CHANS = 2;
  localparam bus_t BUS_IDLE = '{clr: 1'b0, wr_n: 1'b1, cs_n: 1'b1,
                                upd_n: 1'b1, addr: '0, data: '0};

  bus_t bus_raw, bus_s;
  assign bus_raw = '{clr: clr, wr_n: wr_n, cs_n: cs_n, upd_n: upd_n,
                     addr: bus_addr, data: bus_data};

  dnr_sync #(.W(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL(BUS_IDLE)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(bus_raw), .q(bus_s)
  );

  logic              wr_edge, cmd_fire, cmd_upd, clr_apply;
  logic [ADDR_W-1:0] cmd_addr;
  logic [NIB_W-1:0]  cmd_data;

  dnr_cmd_capture u_cap (
    .clk(clk), .rst_n(rst_n), .bus_s(bus_s), .wr_edge(wr_edge),
    .cmd_fire(cmd_fire), .cmd_upd(cmd_upd), .cmd_addr(cmd_addr),
    .cmd_data(cmd_data), .clr_apply(clr_apply)
  );

  // decoded strobes, named for the checker
  logic [NIB_CNT-1:0] nib_we [CHANS];
  logic [CHANS-1:0]   xfer;
  logic [CODE_W-1:0]  in_word [CHANS];
  logic [CODE_W-1:0]  out_code [CHANS];
  logic [NIB_CNT-1:0] nib_we_a, nib_we_b;
  logic               xfer_a, xfer_b;
  logic [CODE_W-1:0]  in_a, in_b;

  genvar c, k;
  generate
    for (c = 0; c < CHANS; c++) begin : g_ch
      logic sel;
      assign sel = (addr_chan(cmd_addr) == c[0]);
      for (k = 0; k < NIB_CNT; k++) begin : g_we
        assign nib_we[c][k] = cmd_fire & sel & ~addr_is_xfer(cmd_addr)
                              & (addr_nib(cmd_addr) == k[1:0]);
      end
      assign xfer[c] = cmd_fire & (cmd_upd | (sel & addr_is_xfer(cmd_addr)));

      dnr_channel u_chan (
        .clk(clk), .rst_n(rst_n), .clr(clr_apply), .nib_we(nib_we[c]),
        .nib_data(cmd_data), .xfer(xfer[c]), .in_word(in_word[c]),
        .out_code(out_code[c])
      );
    end
  endgenerate

  assign nib_we_a = nib_we[0];
  assign nib_we_b = nib_we[1];
  assign xfer_a   = xfer[0];
  assign xfer_b   = xfer[1];
  assign in_a     = in_word[0];
  assign in_b     = in_word[1];
  assign code_a   = out_code[0];
  assign code_b   = out_code[1];
endmodule

// File: rtl/dnr_checker.sv
module dnr_checker
  import dnr_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               clr_apply,
  input logic               cmd_fire,
  input logic               xfer_a,
  input logic               xfer_b,
  input logic [NIB_CNT-1:0] nib_we_a,
  input logic [NIB_CNT-1:0] nib_we_b,
  input logic [CODE_W-1:0]  in_a,
  input logic [CODE_W-1:0]  in_b,
  input logic [CODE_W-1:0]  code_a,
  input logic [CODE_W-1:0]  code_b
);
  a_r1_one_nibble: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({nib_we_a, nib_we_b}));

  a_r2_xfer_a_copies: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_a && !clr_apply) |=> code_a == $past(in_a));

  a_r2_xfer_b_copies: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_b && !clr_apply) |=> code_b == $past(in_b));

  a_r3_idle_holds_inputs: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_fire && !clr_apply) |=> ($stable(in_a) && $stable(in_b)));

  a_r4_a_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer_a && !clr_apply) |=> $stable(code_a));

  a_r4_b_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer_b && !clr_apply) |=> $stable(code_b));

  a_r5_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
    clr_apply |=> (code_a == '0 && code_b == '0 && in_a == '0 && in_b == '0));

  a_r6_both_together: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_a && xfer_b && !clr_apply) |=>
      (code_a == $past(in_a) && code_b == $past(in_b)));
endmodule

bind dual_nibble_dac_regs dnr_checker u_dnr_checker (
  .clk(clk), .rst_n(rst_n), .clr_apply(clr_apply), .cmd_fire(cmd_fire),
  .xfer_a(xfer_a), .xfer_b(xfer_b), .nib_we_a(nib_we_a), .nib_we_b(nib_we_b),
  .in_a(in_a), .in_b(in_b), .code_a(code_a), .code_b(code_b)
);

// File: tb/dual_nibble_dac_regs_bench.sv
module dual_nibble_dac_regs_bench;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic [3:0]  bus_data = '0;
  logic [2:0]  bus_addr = '0;
  logic        cs_n = 1'b1, wr_n = 1'b1, upd_n = 1'b1, clr = 1'b0;
  logic [11:0] code_a, code_b;

  dual_nibble_dac_regs u_dual_nibble_dac_regs (
    .clk(clk), .rst_n(rst_n), .bus_data(bus_data), .bus_addr(bus_addr),
    .cs_n(cs_n), .wr_n(wr_n), .upd_n(upd_n), .clr(clr),
    .code_a(code_a), .code_b(code_b)
  );

  int tests = 0, fails = 0;
  bit done = 0;

  // behavioural reference: event stream delayed three edges (R7)
  int q[$];
  int m_nib [2][3];
  int m_out [2];
  int prev_wr, ev, pe, ch, nb;
  int old_in [2];

  function automatic int word_of(int c);
    return m_nib[c][0] | (m_nib[c][1] << 4) | (m_nib[c][2] << 8);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      q = {0, 0, 0};
      prev_wr = 1;
      for (int i = 0; i < 2; i++) begin
        m_out[i] = 0;
        for (int j = 0; j < 3; j++) m_nib[i][j] = 0;
      end
    end else begin
      ev = 0;
      if (clr) ev |= 1 << 12;
      if (wr_n && prev_wr == 0 && !cs_n) begin
        ev |= 1 << 11;
        if (!upd_n) ev |= 1 << 10;
        ev |= (int'(bus_addr) << 4) | int'(bus_data);
      end
      prev_wr = wr_n;
      q.push_back(ev);
      pe = q.pop_front();
      if (pe[12]) begin
        for (int i = 0; i < 2; i++) begin
          m_out[i] = 0;
          for (int j = 0; j < 3; j++) m_nib[i][j] = 0;
        end
      end else if (pe[11]) begin
        old_in[0] = word_of(0);
        old_in[1] = word_of(1);
        ch = (pe >> 6) & 1;
        nb = (pe >> 4) & 3;
        if (nb == 3) m_out[ch] = old_in[ch];
        else m_nib[ch][nb] = pe & 15;
        if (pe[10]) begin
          m_out[0] = old_in[0];
          m_out[1] = old_in[1];
        end
      end
    end
  end

  // cycle-by-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      tests++;
      if (code_a !== 12'(m_out[0]) || code_b !== 12'(m_out[1])) begin
        fails++;
        $display("FAIL R7 model: code_a=%h code_b=%h expected %h %h",
                 code_a, code_b, m_out[0], m_out[1]);
      end
    end
  end

  task automatic check(string tag, logic [11:0] act, logic [11:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_write(logic [2:0] a, logic [3:0] d, logic upd_low,
                           logic cs_low = 1'b1);
    @(negedge clk);
    bus_addr = a; bus_data = d; cs_n = ~cs_low; upd_n = ~upd_low; wr_n = 1'b0;
    repeat (2) @(negedge clk);
    wr_n = 1'b1;
    repeat (3) @(negedge clk);
    cs_n = 1'b1; upd_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic load_word(logic [2:0] base, logic [11:0] w);
    bus_write(base + 3'd2, w[11:8], 1'b0 ? 1'b1 : 1'b0);
    bus_write(base,        w[3:0],  1'b0);
    bus_write(base + 3'd1, w[7:4],  1'b0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++; tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R8 reset code_a", code_a, 12'h000);
    check("R8 reset code_b", code_b, 12'h000);

    // R1 / R4: load A nibbles, output unchanged until transfer
    load_word(3'd0, 12'h3A5);
    check("R4 A held after nibbles", code_a, 12'h000);
    bus_write(3'd3, 4'h0, 1'b0);
    check("R1 A word after transfer", code_a, 12'h3A5);
    check("R2 B untouched by A transfer", code_b, 12'h000);

    // R4: partial B sequence, no transfer
    bus_write(3'd4, 4'hC, 1'b0);
    bus_write(3'd6, 4'h7, 1'b0);
    check("R4 B held after partial", code_b, 12'h000);
    bus_write(3'd7, 4'h0, 1'b0);
    check("R2 B after transfer", code_b, 12'h70C);
    check("R2 A unchanged", code_a, 12'h3A5);

    // R3: chip select inactive
    bus_write(3'd0, 4'hF, 1'b0, 1'b0);
    bus_write(3'd3, 4'h0, 1'b1, 1'b0);
    check("R3 A after deselected writes", code_a, 12'h3A5);
    check("R3 B after deselected writes", code_b, 12'h70C);

    // R6: load new words, then simultaneous update on a nibble address
    load_word(3'd0, 12'h1B2);
    load_word(3'd4, 12'hE4D);
    bus_write(3'd0, 4'h9, 1'b1);   // update uses old A low nibble 2
    check("R6 A same cycle update", code_a, 12'h1B2);
    check("R6 B same cycle update", code_b, 12'hE4D);
    bus_write(3'd7, 4'h0, 1'b1);   // update plus transfer code
    check("R6 A with transfer code", code_a, 12'h1B9);
    check("R6 B with transfer code", code_b, 12'hE4D);

    // R7: wr_n held low, data changes, only the value at rise counts
    @(negedge clk);
    cs_n = 1'b0; bus_addr = 3'd3; wr_n = 1'b0;
    repeat (6) @(negedge clk);
    check("R7 no action while wr_n low", code_a, 12'h1B9);
    bus_addr = 3'd1;
    for (int i = 0; i < 4; i++) begin
      bus_data = 4'(i + 2);
      @(negedge clk);
    end
    wr_n = 1'b1;
    repeat (3) @(negedge clk);
    cs_n = 1'b1;
    repeat (3) @(negedge clk);
    bus_write(3'd3, 4'h0, 1'b0);
    check("R7 last data at rise", code_a, 12'h159);

    // R5: clear coinciding with a write
    @(negedge clk);
    cs_n = 1'b0; upd_n = 1'b0; bus_addr = 3'd2; bus_data = 4'hF; wr_n = 1'b0;
    repeat (2) @(negedge clk);
    wr_n = 1'b1; clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    repeat (3) @(negedge clk);
    cs_n = 1'b1; upd_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R5 A cleared", code_a, 12'h000);
    check("R5 B cleared", code_b, 12'h000);
    bus_write(3'd3, 4'h0, 1'b1);
    check("R5 A inputs cleared", code_a, 12'h000);
    check("R5 B inputs cleared", code_b, 12'h000);

    repeat (4) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule